// File: doc/BRIEF.md
# Mailbox Transmit Register Block

This block is the sending half of an inter-processor mailbox as one core sees it. Software stages a 64-bit message as two 32-bit words, selects one of eight destination cores, and writes a trigger. If the destination has no message outstanding, the block launches the message on a one-cycle output strobe. It also marks that destination busy until the remote side reports a fetch.

The block keeps three bitmaps, one bit per destination, in a single status word:
- busy: a message is outstanding.
- overflow: a trigger was dropped because the destination was still busy.
- delivered: the remote side has fetched a message.

Delivered and overflow bits stay set until software clears them by writing a bit pattern. Each delivered or overflow event can raise an interrupt. Both event sources and the interrupt output have their own mask bits. A fetch strobe with a destination index stands in for the remote side.

The register bus is a single-cycle request interface. Read data is registered and appears one cycle after the read request.

Top module: `mbx_send_regs`

## Requirements
- R1: After reset the status word (offset 0x14) reads 0, the interrupt pending word (0x18) reads 0, the mask word (0x1C) reads 0x7 (every source masked), `irq_o` is low and `launch_valid_o` is low. Read data appears one cycle after the read request.
- R2: Writes to offset 0x0 store a destination index from bits 2:0, which reads back zero-extended. Writes to 0x4 and 0x8 store the low and high message words, which read back unchanged.
- R3: A write to 0x0C with bit 0 set, while the selected destination is not busy, raises `launch_valid_o` for exactly one cycle, starting one cycle after the write. With it come the destination on `launch_tgt_o` and the message {high,low} on `launch_data_o`. The destination's busy bit, bit 0+t of the status word, is then set. A write to 0x0C with bit 0 clear does nothing.
- R4: A trigger aimed at a busy destination t launches nothing, leaves busy unchanged and sets overflow bit 8+t of the status word.
- R5: A fetch strobe for a busy destination t clears busy bit t and sets delivered bit 16+t. A fetch strobe for a destination that is not busy changes nothing. Status bits 31:24 read zero.
- R6: A write to offset 0x10 clears each delivered bit (23:16) and each overflow bit (15:8) whose position is 1 in the written value. It leaves busy bits and the other status bits alone.
- R7: Mask bit 1 blocks overflow events and mask bit 2 blocks delivered events. An unblocked event sets the pending bit (bit 0 of 0x18). A blocked event leaves it clear.
- R8: `irq_o` equals the pending bit gated by mask bit 0: it is high only when pending is set and mask bit 0 is 0.
- R9: Writing 1 to bit 0 of offset 0x18 clears the pending bit and drops `irq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid_i | input | 1 | Register access request |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 6 | Byte offset of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid the cycle after a read request |
| fetch_valid_i | input | 1 | Remote side has fetched a message |
| fetch_tgt_i | input | 3 | Destination whose message was fetched |
| launch_valid_o | output | 1 | One-cycle strobe: a message is launched |
| launch_tgt_o | output | 3 | Destination of the launched message |
| launch_data_o | output | 64 | Launched message {high, low} |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest state to reach is a destination with overflow, delivered and busy bits all live at once while the interrupt masks are partly open. This matters because the clear write and the masked-event paths are only meaningful against such a mixed status word. The stimulus builds it in steps:
- A double trigger to one destination creates an overflow.
- A fetch turns that destination's outstanding message into a delivered bit.
- A fresh send to a second destination leaves it busy.
- Selective clears and partial masks are then applied to this mixed state.

Launched messages are pushed into an expected queue by the send task and compared by a monitor as the strobes appear. This catches any launch that should have been dropped.

// File: rtl/mbx_pkg.sv
// Shared constants for the mailbox transmit block: register offsets and
// interrupt mask bit positions. Assumes byte offsets on a 32-bit bus.
package mbx_pkg;
    localparam int OFF_TGT   = 'h00;
    localparam int OFF_LO    = 'h04;
    localparam int OFF_HI    = 'h08;
    localparam int OFF_TRIG  = 'h0C;
    localparam int OFF_CLR   = 'h10;
    localparam int OFF_STAT  = 'h14;
    localparam int OFF_PEND  = 'h18;
    localparam int OFF_MASK  = 'h1C;

    localparam int MSK_OUT_BIT = 0;
    localparam int MSK_OVF_BIT = 1;
    localparam int MSK_DLV_BIT = 2;
    localparam int MSK_W       = 3;
endpackage

// File: rtl/mbx_stage.sv
// Staging registers for the next message: destination index and two data
// words. Assumes the write strobes are mutually exclusive.
module mbx_stage #(
    parameter int DATA_W = 32,
    parameter int TGT_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_tgt,
    input  logic              we_lo,
    input  logic              we_hi,
    input  logic [DATA_W-1:0] wdata,
    output logic [TGT_W-1:0]  tgt_q,
    output logic [DATA_W-1:0] lo_q,
    output logic [DATA_W-1:0] hi_q
);
    // Capture each staged field on its own write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgt_q <= '0;
            lo_q  <= '0;
            hi_q  <= '0;
        end else begin
            if (we_tgt) tgt_q <= wdata[TGT_W-1:0];
            if (we_lo)  lo_q  <= wdata;
            if (we_hi)  hi_q  <= wdata;
        end
    end
endmodule

// File: rtl/mbx_status.sv
// Per-destination busy, overflow and delivered bitmaps. A trigger to an idle
// destination marks it busy; one to a busy destination records an overflow.
// A fetch of a busy destination clears busy and records delivery. New events
// take priority over a software clear in the same cycle.
module mbx_status #(
    parameter int NT    = 8,
    parameter int TGT_W = $clog2(NT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig,
    input  logic [TGT_W-1:0] trig_tgt,
    input  logic             fetch_valid,
    input  logic [TGT_W-1:0] fetch_tgt,
    input  logic             clr_we,
    input  logic [NT-1:0]    clr_ovf,
    input  logic [NT-1:0]    clr_dlv,
    output logic [NT-1:0]    busy_q,
    output logic [NT-1:0]    ovf_q,
    output logic [NT-1:0]    dlv_q,
    output logic             launch_ok,
    output logic             ev_ovf,
    output logic             ev_dlv
);
    // Classify the current trigger and fetch against the busy map.
    always_comb begin
        launch_ok = trig && !busy_q[trig_tgt];
        ev_ovf    = trig && busy_q[trig_tgt];
        ev_dlv    = fetch_valid && busy_q[fetch_tgt];
    end

    for (genvar g = 0; g < NT; g++) begin : g_tgt
        logic hit_trig, hit_fetch;
        assign hit_trig  = trig && (trig_tgt == TGT_W'(g));
        assign hit_fetch = fetch_valid && (fetch_tgt == TGT_W'(g));

        // Update this destination's three status bits.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                busy_q[g] <= 1'b0;
                ovf_q[g]  <= 1'b0;
                dlv_q[g]  <= 1'b0;
            end else begin
                busy_q[g] <= (hit_trig && !busy_q[g]) ||
                             (busy_q[g] && !hit_fetch);
                ovf_q[g]  <= (hit_trig && busy_q[g]) ||
                             (ovf_q[g] && !(clr_we && clr_ovf[g]));
                dlv_q[g]  <= (hit_fetch && busy_q[g]) ||
                             (dlv_q[g] && !(clr_we && clr_dlv[g]));
            end
        end
    end

    // R4
    ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && busy_q[trig_tgt]) |=> (ovf_q[$past(trig_tgt)] && busy_q[$past(trig_tgt)]));

    // R5
    fetch_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid && busy_q[fetch_tgt]) |=> (!busy_q[$past(fetch_tgt)] && dlv_q[$past(fetch_tgt)]));

    // R3
    busy_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (trig && !busy_q[trig_tgt] && !(fetch_valid && fetch_tgt == trig_tgt))
        |=> busy_q[$past(trig_tgt)]);
endmodule

// File: rtl/mbx_irq.sv
// Interrupt pending bit with per-source masks and an output gate. Pending is
// set by any event whose mask bit is clear and is cleared by software
// writing 1; a same-cycle event wins. Mask resets to all sources blocked.
module mbx_irq #(
    parameter int MSK_W = mbx_pkg::MSK_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mask_we,
    input  logic [MSK_W-1:0] mask_wd,
    input  logic             pend_clr,
    input  logic             ev_ovf,
    input  logic             ev_dlv,
    output logic [MSK_W-1:0] mask_q,
    output logic             pend_q,
    output logic             irq_o
);
    import mbx_pkg::*;

    logic ev_open;

    // Keep only events whose source mask is open.
    always_comb begin
        ev_open = (ev_ovf && !mask_q[MSK_OVF_BIT]) ||
                  (ev_dlv && !mask_q[MSK_DLV_BIT]);
    end

    // Hold the mask and the pending bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '1;
            pend_q <= 1'b0;
        end else begin
            if (mask_we) mask_q <= mask_wd;
            pend_q <= ev_open || (pend_q && !pend_clr);
        end
    end

    // Gate the output with the global mask bit.
    assign irq_o = pend_q && !mask_q[MSK_OUT_BIT];

    // R7
    pend_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pend_q && !ev_ovf && !ev_dlv) |=> !pend_q);

    // R7
    pend_dlv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_dlv && !mask_q[MSK_DLV_BIT]) |=> pend_q);

    // R9
    pend_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_clr && !ev_ovf && !ev_dlv) |=> !pend_q);
endmodule

// File: rtl/mbx_send_regs.sv
// Top of the mailbox transmit block: decodes the register bus, stages the
// message, tracks per-destination status, launches messages and raises the
// interrupt. Assumes one bus access per cycle; read data is registered.
module mbx_send_regs #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 6,
    parameter int NT     = 8,
    parameter int TGT_W  = $clog2(NT)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_valid_i,
    input  logic                bus_write_i,
    input  logic [ADDR_W-1:0]   bus_addr_i,
    input  logic [DATA_W-1:0]   bus_wdata_i,
    output logic [DATA_W-1:0]   bus_rdata_o,
    input  logic                fetch_valid_i,
    input  logic [TGT_W-1:0]    fetch_tgt_i,
    output logic                launch_valid_o,
    output logic [TGT_W-1:0]    launch_tgt_o,
    output logic [2*DATA_W-1:0] launch_data_o,
    output logic                irq_o
);
    import mbx_pkg::*;

    localparam int OVF_LSB = NT;
    localparam int DLV_LSB = 2 * NT;

    logic wr, rd;
    logic we_tgt, we_lo, we_hi, trig, clr_we, mask_we, pend_clr;
    logic [TGT_W-1:0]  tgt_q;
    logic [DATA_W-1:0] lo_q, hi_q;
    logic [NT-1:0]     busy_q, ovf_q, dlv_q;
    logic              launch_ok, ev_ovf, ev_dlv, pend_q;
    logic [MSK_W-1:0]  mask_q;
    logic [DATA_W-1:0] stat_word, rd_next;

    // Decode register writes from the bus request.
    always_comb begin
        wr       = bus_valid_i && bus_write_i;
        rd       = bus_valid_i && !bus_write_i;
        we_tgt   = wr && (bus_addr_i == OFF_TGT[ADDR_W-1:0]);
        we_lo    = wr && (bus_addr_i == OFF_LO[ADDR_W-1:0]);
        we_hi    = wr && (bus_addr_i == OFF_HI[ADDR_W-1:0]);
        trig     = wr && (bus_addr_i == OFF_TRIG[ADDR_W-1:0]) && bus_wdata_i[0];
        clr_we   = wr && (bus_addr_i == OFF_CLR[ADDR_W-1:0]);
        mask_we  = wr && (bus_addr_i == OFF_MASK[ADDR_W-1:0]);
        pend_clr = wr && (bus_addr_i == OFF_PEND[ADDR_W-1:0]) && bus_wdata_i[0];
    end

    mbx_stage #(.DATA_W(DATA_W), .TGT_W(TGT_W)) u_stage (
        .clk   (clk),
        .rst_n (rst_n),
        .we_tgt(we_tgt),
        .we_lo (we_lo),
        .we_hi (we_hi),
        .wdata (bus_wdata_i),
        .tgt_q (tgt_q),
        .lo_q  (lo_q),
        .hi_q  (hi_q)
    );

    mbx_status #(.NT(NT), .TGT_W(TGT_W)) u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .trig       (trig),
        .trig_tgt   (tgt_q),
        .fetch_valid(fetch_valid_i),
        .fetch_tgt  (fetch_tgt_i),
        .clr_we     (clr_we),
        .clr_ovf    (bus_wdata_i[OVF_LSB +: NT]),
        .clr_dlv    (bus_wdata_i[DLV_LSB +: NT]),
        .busy_q     (busy_q),
        .ovf_q      (ovf_q),
        .dlv_q      (dlv_q),
        .launch_ok  (launch_ok),
        .ev_ovf     (ev_ovf),
        .ev_dlv     (ev_dlv)
    );

    mbx_irq #(.MSK_W(MSK_W)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .mask_we (mask_we),
        .mask_wd (bus_wdata_i[MSK_W-1:0]),
        .pend_clr(pend_clr),
        .ev_ovf  (ev_ovf),
        .ev_dlv  (ev_dlv),
        .mask_q  (mask_q),
        .pend_q  (pend_q),
        .irq_o   (irq_o)
    );

    // Register the launch strobe together with its payload.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            launch_valid_o <= 1'b0;
            launch_tgt_o   <= '0;
            launch_data_o  <= '0;
        end else begin
            launch_valid_o <= launch_ok;
            if (launch_ok) begin
                launch_tgt_o  <= tgt_q;
                launch_data_o <= {hi_q, lo_q};
            end
        end
    end

    // Assemble the status word and select the read source.
    always_comb begin
        stat_word = '0;
        stat_word[NT-1:0]           = busy_q;
        stat_word[OVF_LSB +: NT]    = ovf_q;
        stat_word[DLV_LSB +: NT]    = dlv_q;
        rd_next = '0;
        case (int'(bus_addr_i))
            OFF_TGT:  rd_next[TGT_W-1:0] = tgt_q;
            OFF_LO:   rd_next = lo_q;
            OFF_HI:   rd_next = hi_q;
            OFF_STAT: rd_next = stat_word;
            OFF_PEND: rd_next[0] = pend_q;
            OFF_MASK: rd_next[MSK_W-1:0] = mask_q;
            default:  rd_next = '0;
        endcase
    end

    // Return read data one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) bus_rdata_o <= '0;
        else if (rd) bus_rdata_o <= rd_next;
    end

    // R3
    launch_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        launch_ok |=> launch_valid_o);

    // R4
    no_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !launch_ok |=> !launch_valid_o);

    // R8
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (pend_q && !mask_q[MSK_OUT_BIT]));
endmodule

// File: tb/sim_mbx_send_regs.sv
module sim_mbx_send_regs;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid_i = 1'b0, bus_write_i = 1'b0;
    logic [5:0]  bus_addr_i = '0;
    logic [31:0] bus_wdata_i = '0;
    logic [31:0] bus_rdata_o;
    logic        fetch_valid_i = 1'b0;
    logic [2:0]  fetch_tgt_i = '0;
    logic        launch_valid_o;
    logic [2:0]  launch_tgt_o;
    logic [63:0] launch_data_o;
    logic        irq_o;

    int checks = 0, errors = 0;
    bit done = 0;
    logic [66:0] exp_q[$];
    logic [2:0]  cur_tgt;
    logic [31:0] cur_lo, cur_hi;

    always #(CLK_PERIOD/2) clk = ~clk;

    mbx_send_regs u0 (
        .clk(clk), .rst_n(rst_n),
        .bus_valid_i(bus_valid_i), .bus_write_i(bus_write_i),
        .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i),
        .bus_rdata_o(bus_rdata_o),
        .fetch_valid_i(fetch_valid_i), .fetch_tgt_i(fetch_tgt_i),
        .launch_valid_o(launch_valid_o), .launch_tgt_o(launch_tgt_o),
        .launch_data_o(launch_data_o), .irq_o(irq_o)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid_i = 1; bus_write_i = 1; bus_addr_i = a; bus_wdata_i = d;
        @(negedge clk);
        bus_valid_i = 0; bus_write_i = 0;
    endtask

    task automatic rd(input logic [5:0] a, input logic [31:0] exp, input string req);
        @(negedge clk);
        bus_valid_i = 1; bus_write_i = 0; bus_addr_i = a;
        @(negedge clk);
        bus_valid_i = 0;
        check(req, {32'b0, bus_rdata_o}, {32'b0, exp});
    endtask

    task automatic stage(input logic [2:0] t, input logic [31:0] lo, input logic [31:0] hi);
        wr(6'h00, {29'h1FFFFFFF, t});
        wr(6'h04, lo);
        wr(6'h08, hi);
        cur_tgt = t; cur_lo = lo; cur_hi = hi;
    endtask

    // Driver: trigger a send, pushing an expected launch if the target is idle.
    task automatic send(input bit expect_launch);
        if (expect_launch) exp_q.push_back({cur_tgt, cur_hi, cur_lo});
        wr(6'h0C, 32'h1);
    endtask

    task automatic fetch(input logic [2:0] t);
        @(negedge clk);
        fetch_valid_i = 1; fetch_tgt_i = t;
        @(negedge clk);
        fetch_valid_i = 0;
    endtask

    // Monitor: compare every launch against the scoreboard queue (R3, R4).
    always @(negedge clk) begin
        if (rst_n && launch_valid_o) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R4: unexpected launch actual tgt %0d data 0x%0h expected none",
                         launch_tgt_o, launch_data_o);
            end else begin
                logic [66:0] e;
                e = exp_q.pop_front();
                check("R3 launch", {launch_tgt_o, launch_data_o}, e);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        check("R1 irq", {63'b0, irq_o}, 64'd0);
        check("R1 launch", {63'b0, launch_valid_o}, 64'd0);
        rd(6'h14, 32'h0, "R1 status");
        rd(6'h18, 32'h0, "R1 pending");
        rd(6'h1C, 32'h7, "R1 mask");
        // R2 staging readback
        stage(3'd3, 32'h1234_5678, 32'h9ABC_DEF0);
        rd(6'h00, 32'h3, "R2 target");
        rd(6'h04, 32'h1234_5678, "R2 low");
        rd(6'h08, 32'h9ABC_DEF0, "R2 high");
        // R3 trigger with bit0 clear does nothing
        wr(6'h0C, 32'hFFFF_FFFE);
        rd(6'h14, 32'h0, "R3 no trigger");
        // R3 real launch
        send(1);
        rd(6'h14, 32'h0000_0008, "R3 busy");
        // R4 overflow, masked source leaves pending clear (R7)
        send(0);
        rd(6'h14, 32'h0000_0808, "R4 overflow");
        rd(6'h18, 32'h0, "R7 masked overflow");
        // R5 fetch, unmasked deliver sets pending (R7)
        wr(6'h1C, 32'h0);
        fetch(3'd3);
        rd(6'h14, 32'h0008_0800, "R5 delivered");
        rd(6'h18, 32'h1, "R7 pending");
        check("R8 irq on", {63'b0, irq_o}, 64'd1);
        fetch(3'd5);
        rd(6'h14, 32'h0008_0800, "R5 idle fetch");
        // R8 output gate
        wr(6'h1C, 32'h1);
        check("R8 irq gated", {63'b0, irq_o}, 64'd0);
        wr(6'h1C, 32'h0);
        check("R8 irq open", {63'b0, irq_o}, 64'd1);
        // R9 clear pending
        wr(6'h18, 32'h1);
        check("R9 irq low", {63'b0, irq_o}, 64'd0);
        rd(6'h18, 32'h0, "R9 pending");
        // R6 clear keeps busy
        stage(3'd6, 32'hCAFE_0006, 32'h0BAD_0006);
        send(1);
        rd(6'h14, 32'h0008_0840, "R6 before clear");
        wr(6'h10, 32'hFFFF_FFFF);
        rd(6'h14, 32'h0000_0040, "R6 busy kept");
        // R7 deliver masked, overflow open
        wr(6'h1C, 32'h4);
        send(0);
        rd(6'h14, 32'h0000_4040, "R4 overflow t6");
        rd(6'h18, 32'h1, "R7 overflow open");
        wr(6'h18, 32'h1);
        fetch(3'd6);
        rd(6'h14, 32'h0040_4000, "R5 deliver t6");
        rd(6'h18, 32'h0, "R7 deliver masked");
        // R6 selective clear of overflow only
        wr(6'h10, 32'h0000_4000);
        rd(6'h14, 32'h0040_0000, "R6 selective");
        // R3/R5 extreme destinations
        for (int i = 0; i < 2; i++) begin
            logic [2:0] t;
            t = (i == 0) ? 3'd0 : 3'd7;
            stage(t, 32'h1111_1111 * (i + 1), ~(32'h1111_1111 * (i + 1)));
            send(1);
            fetch(t);
        end
        rd(6'h14, 32'h00C1_0000, "R5 edge targets");
        repeat (3) @(negedge clk);
        check("R3 queue drained", 64'(exp_q.size()), 64'd0);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule